// File: doc/BRIEF.md
# EEPROM page write buffer controller

This block sits behind the serial bus decoder of a byte-wide EEPROM. During a write transaction it gathers the incoming data bytes into a one-row page latch. A starting address is loaded first. Its upper bits pick the row and stay fixed for the whole transaction. Its lower `COL_W` bits form a column counter that advances after every byte and wraps inside the row. A per-column valid bit records which columns hold fresh data, so a later byte that lands on a column already filled replaces the earlier one.

When the decoder reports a STOP that came right after a data byte's acknowledge, the block enters a self-timed write cycle. It raises `busy` for exactly `WRITE_CYCLES` clocks and, during that window, presents the loaded columns on the array write port one per clock. A STOP in any other position, an abort (for example a repeated START), or a transaction that saw a byte under write inhibit throws the latch away and writes nothing. A small array model that powers up to all ones comes with the block for test benches.

Top module: `pgw_ctrl`

## Requirements
- R1: While `rst_n` is low and after reset, `busy` and `mem_we` are 0.
- R2: An `addr_load` takes row = `addr_in[15:7]` and column = `addr_in[6:0]`; each accepted byte goes to the current column, the column then advances by one, and every write of the later commit carries the loaded row in `mem_addr[15:7]`.
- R3: The column wraps from 127 to 0 without touching the row; a byte landing on a column already loaded in the same transaction replaces the earlier value.
- R4: A transaction of a single byte commits exactly that one location; up to 128 distinct columns can be committed at once.
- R5: A commit starts only when `stop_stb` and `stop_at_ack` are both high, at least one byte is latched and no byte of the transaction arrived under inhibit; `busy` rises on the next clock.
- R6: A `stop_stb` with `stop_at_ack` low discards the latch: no busy, no writes, and a later valid STOP without new bytes does nothing.
- R7: A byte received while `wr_inhibit` is high is not latched, and the transaction it belongs to commits nothing.
- R8: `busy` stays high for exactly `WRITE_CYCLES` clocks and drops on the clock the count runs out.
- R9: During busy, column c is presented in busy cycle c (counted from 0), only for loaded columns, in ascending column order, with `mem_we` high for one clock and `mem_we` never high outside busy.
- R10: While `busy` is high every strobe input is ignored.
- R11: `abort` clears every latched byte without writing; a following valid STOP commits nothing.
- R12: The array model holds FFh in every byte after reset and keeps it where nothing was written.
- R13: When strobes coincide, `abort` wins over `stop_stb`, which wins over `addr_load`, which wins over `byte_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Strobe: take `addr_in` as the start address |
| addr_in | input | 16 | Start address, row in bits 15:7, column in bits 6:0 |
| byte_stb | input | 1 | Strobe: one data byte has been received |
| byte_in | input | 8 | Data byte |
| wr_inhibit | input | 1 | High: the byte of this strobe is write-protected |
| stop_stb | input | 1 | Strobe: STOP seen on the bus |
| stop_at_ack | input | 1 | High: that STOP followed a data acknowledge directly |
| abort | input | 1 | Strobe: drop the transaction without writing |
| busy | output | 1 | Self-timed write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 16 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The main function is tried with a single byte, with a short page that crosses the row end, and with 130 bytes that overfill the row; together these tell apart a correct column wrap and replacement from row carry or duplicate writes. Discard paths are tried separately: a misplaced STOP, an inhibited byte and an abort each precede a valid STOP, which shows the latch was truly emptied rather than only the commit being skipped. A commit is also fed strobes while busy to show they leave no trace, and the array is read back at written and untouched locations.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;

    // One decoded command per clock, highest priority first in the decode.
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_ABORT,
        CMD_STOP,
        CMD_LOAD,
        CMD_BYTE
    } pgw_cmd_e;

endpackage

// File: rtl/pgw_page_buf.sv
`timescale 1ns/1ps
module pgw_page_buf #(
    parameter int COL_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [COL_W-1:0]  wr_col,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_all,
    input  logic              clr_en,
    input  logic [COL_W-1:0]  clr_col,
    input  logic [COL_W-1:0]  rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int PAGE = 1 << COL_W;

    logic [PAGE-1:0]   vld_all;
    logic [DATA_W-1:0] dat_all [PAGE];

    // One latch slot per column: data plus a loaded flag.
    for (genvar c = 0; c < PAGE; c++) begin : g_col
        typedef struct packed {
            logic              vld;
            logic [DATA_W-1:0] dat;
        } slot_t;

        slot_t slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (clr_all || (clr_en && clr_col == COL_W'(c))) begin
                slot_d.vld = 1'b0;
            end
            if (wr_en && wr_col == COL_W'(c)) begin
                slot_d.vld = 1'b1;
                slot_d.dat = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '{vld: 1'b0, dat: {DATA_W{1'b1}}};
            end else begin
                slot_q <= slot_d;
            end
        end

        assign vld_all[c] = slot_q.vld;
        assign dat_all[c] = slot_q.dat;
    end

    assign rd_data   = dat_all[rd_col];
    assign rd_valid  = vld_all[rd_col];
    assign any_valid = |vld_all;

endmodule

// File: rtl/pgw_wtimer.sv
`timescale 1ns/1ps
module pgw_wtimer #(
    parameter int CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - CW'(1);
            end
        end else if (start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = tmr_q.busy;

endmodule

// File: rtl/pgw_mem.sv
`timescale 1ns/1ps
module pgw_mem #(
    parameter int MEM_AW = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] cell_q [DEPTH];

    // Erased state is all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= {DATA_W{1'b1}};
            end
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/pgw_ctrl.sv
`timescale 1ns/1ps
module pgw_ctrl #(
    parameter int ADDR_W       = 16,
    parameter int COL_W        = 7,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              wr_inhibit,
    input  logic              stop_stb,
    input  logic              stop_at_ack,
    input  logic              abort,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    import pgw_pkg::*;

    localparam int ROW_W = ADDR_W - COL_W;
    localparam int PAGE  = 1 << COL_W;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             blocked;
        logic [COL_W-1:0] scan;
        logic             scan_done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    pgw_cmd_e         cmd;
    logic             tmr_start;
    logic             buf_we;
    logic             buf_clr_all;
    logic             buf_clr_en;
    logic [DATA_W-1:0] buf_rd_data;
    logic             buf_rd_valid;
    logic             buf_any;

    // Strobe priority: abort, stop, address load, data byte.
    always_comb begin
        if (abort)          cmd = CMD_ABORT;
        else if (stop_stb)  cmd = CMD_STOP;
        else if (addr_load) cmd = CMD_LOAD;
        else if (byte_stb)  cmd = CMD_BYTE;
        else                cmd = CMD_NONE;
    end

    always_comb begin
        ctl_d       = ctl_q;
        tmr_start   = 1'b0;
        buf_we      = 1'b0;
        buf_clr_all = 1'b0;
        buf_clr_en  = 1'b0;
        if (!busy) begin
            unique case (cmd)
                CMD_ABORT: begin
                    buf_clr_all   = 1'b1;
                    ctl_d.blocked = 1'b0;
                end
                CMD_STOP: begin
                    if (stop_at_ack && buf_any && !ctl_q.blocked) begin
                        tmr_start       = 1'b1;
                        ctl_d.scan      = '0;
                        ctl_d.scan_done = 1'b0;
                    end else begin
                        buf_clr_all = 1'b1;
                    end
                    ctl_d.blocked = 1'b0;
                end
                CMD_LOAD: begin
                    ctl_d.row     = addr_in[ADDR_W-1:COL_W];
                    ctl_d.col     = addr_in[COL_W-1:0];
                    ctl_d.blocked = 1'b0;
                    buf_clr_all   = 1'b1;
                end
                CMD_BYTE: begin
                    if (wr_inhibit) begin
                        ctl_d.blocked = 1'b1;
                    end else begin
                        buf_we = 1'b1;
                    end
                    ctl_d.col = ctl_q.col + COL_W'(1);
                end
                default: ;
            endcase
        end else if (!ctl_q.scan_done) begin
            buf_clr_en = 1'b1;
            if (ctl_q.scan == COL_W'(PAGE - 1)) begin
                ctl_d.scan_done = 1'b1;
            end else begin
                ctl_d.scan = ctl_q.scan + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{row: '0, col: '0, blocked: 1'b0, scan: '0, scan_done: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pgw_page_buf #(
        .COL_W  (COL_W),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (buf_we),
        .wr_col    (ctl_q.col),
        .wr_data   (byte_in),
        .clr_all   (buf_clr_all),
        .clr_en    (buf_clr_en),
        .clr_col   (ctl_q.scan),
        .rd_col    (ctl_q.scan),
        .rd_data   (buf_rd_data),
        .rd_valid  (buf_rd_valid),
        .any_valid (buf_any)
    );

    pgw_wtimer #(
        .CYC (WRITE_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .busy  (busy)
    );

    assign mem_we    = busy && !ctl_q.scan_done && buf_rd_valid;
    assign mem_addr  = {ctl_q.row, ctl_q.scan};
    assign mem_wdata = buf_rd_data;

endmodule

// File: rtl/pgw_ctrl_chk.sv
`timescale 1ns/1ps
module pgw_ctrl_chk #(
    parameter int ADDR_W       = 16,
    parameter int COL_W        = 7,
    parameter int WRITE_CYCLES = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_stb,
    input logic              stop_at_ack,
    input logic              abort,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int CW = $clog2(WRITE_CYCLES + 2);

    logic [CW-1:0] busy_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_len_q <= '0;
        end else if (busy) begin
            busy_len_q <= busy_len_q + CW'(1);
        end else begin
            busy_len_q <= '0;
        end
    end

    assert_we_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_stb && stop_at_ack && !abort));

    assert_busy_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len_q == CW'(WRITE_CYCLES));

    assert_row_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && busy && $past(mem_we) && $past(busy))
            |-> mem_addr[ADDR_W-1:COL_W] == $past(mem_addr[ADDR_W-1:COL_W]));

    assert_col_ascending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && busy && $past(mem_we) && $past(busy))
            |-> mem_addr[COL_W-1:0] > $past(mem_addr[COL_W-1:0]));

endmodule

bind pgw_ctrl pgw_ctrl_chk #(
    .ADDR_W       (ADDR_W),
    .COL_W        (COL_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_stb    (stop_stb),
    .stop_at_ack (stop_at_ack),
    .abort       (abort),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr)
);

// File: tb/pgw_ctrl_bench.sv
`timescale 1ns/1ps
module pgw_ctrl_bench;
    localparam int W  = 140;
    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        addr_load, byte_stb, wr_inhibit, stop_stb, stop_at_ack, abort;
    logic [15:0] addr_in;
    logic [7:0]  byte_in;
    logic        busy, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [AW-1:0] rd_addr;
    logic [7:0]  rd_data;

    always #2.5 clk = ~clk;

    pgw_ctrl #(.WRITE_CYCLES(W)) u_pgw_ctrl (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .byte_stb(byte_stb), .byte_in(byte_in), .wr_inhibit(wr_inhibit),
        .stop_stb(stop_stb), .stop_at_ack(stop_at_ack), .abort(abort),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    pgw_mem #(.MEM_AW(AW), .DATA_W(8)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_addr[AW-1:0]),
        .wdata(mem_wdata), .raddr(rd_addr), .rdata(rd_data)
    );

    // Reference model state
    int  m_busy, m_left, m_idx, m_row, m_col;
    bit  m_blk;
    int  m_mask[int];
    int  m_pcol[$];
    int  m_pdat[$];
    int  m_mem[int];

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    task automatic report(string req, bit ok, string got, string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %s expected %s", req, got, exp);
        end
    endtask

    task automatic step(bit ab, bit st, bit sok, bit ld, int addr, bit bs, int bd, bit inh);
        bit exp_we;
        int exp_addr, exp_dat;
        bit ok;
        @(negedge clk);
        exp_we   = (m_busy != 0) && (m_pcol.size() > 0) && (m_pcol[0] == m_idx);
        exp_addr = exp_we ? ((m_row << 7) | m_pcol[0]) : 0;
        exp_dat  = exp_we ? m_pdat[0] : 0;
        ok = (busy == (m_busy != 0)) && (mem_we == exp_we);
        if (exp_we) ok = ok && (int'(mem_addr) == exp_addr) && (int'(mem_wdata) == exp_dat);
        report(cur_req, ok,
               $sformatf("busy=%0d we=%0d addr=%04h data=%02h", busy, mem_we, mem_addr, mem_wdata),
               $sformatf("busy=%0d we=%0d addr=%04h data=%02h", m_busy != 0, exp_we, exp_addr, exp_dat));
        abort = ab; stop_stb = st; stop_at_ack = sok; addr_load = ld;
        addr_in = 16'(addr); byte_stb = bs; byte_in = 8'(bd); wr_inhibit = inh;
        if (m_busy != 0) begin
            if (exp_we) begin
                m_mem[exp_addr] = exp_dat;
                void'(m_pcol.pop_front());
                void'(m_pdat.pop_front());
            end
            m_idx++;
            m_left--;
            if (m_left == 0) m_busy = 0;
        end else if (ab) begin
            m_mask.delete(); m_blk = 0;
        end else if (st) begin
            if (sok && m_mask.num() > 0 && !m_blk) begin
                for (int c = 0; c < 128; c++) begin
                    if (m_mask.exists(c)) begin
                        m_pcol.push_back(c);
                        m_pdat.push_back(m_mask[c]);
                    end
                end
                m_busy = 1; m_left = W; m_idx = 0;
            end
            m_mask.delete(); m_blk = 0;
        end else if (ld) begin
            m_row = addr >> 7; m_col = addr & 127; m_mask.delete(); m_blk = 0;
        end else if (bs) begin
            if (inh) m_blk = 1;
            else m_mask[m_col] = bd & 255;
            m_col = (m_col + 1) % 128;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic do_load(int a);        step(0, 0, 0, 1, a, 0, 0, 0); endtask
    task automatic do_byte(int d, bit i); step(0, 0, 0, 0, 0, 1, d, i); endtask
    task automatic do_stop(bit ok);       step(0, 1, ok, 0, 0, 0, 0, 0); endtask
    task automatic do_abort();            step(1, 0, 0, 0, 0, 0, 0, 0); endtask

    task automatic mem_chk(string req, int a);
        int exp;
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        exp = m_mem.exists(a) ? m_mem[a] : 255;
        report(req, int'(rd_data) == exp, $sformatf("mem[%04h]=%02h", a, rd_data),
               $sformatf("%02h", exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog got hang expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rd_addr = '0;
        abort = 0; stop_stb = 0; stop_at_ack = 0; addr_load = 0;
        addr_in = '0; byte_stb = 0; byte_in = '0; wr_inhibit = 0;
        m_busy = 0; m_left = 0; m_idx = 0; m_row = 0; m_col = 0; m_blk = 0;
        // R1: outputs quiet during reset
        repeat (3) begin
            @(negedge clk);
            report("R1", !busy && !mem_we, $sformatf("busy=%0d we=%0d", busy, mem_we), "0 0");
        end
        rst_n = 1'b1;
        cur_req = "R1"; idle(3);
        mem_chk("R12", 12'h105);

        // R4: single byte commit; R5 busy rises next clock; R8 length; R9 order
        cur_req = "R4/R5/R8/R9";
        do_load(16'h0105); do_byte(8'h3C, 0); do_stop(1); idle(W + 3);
        mem_chk("R4", 16'h0105);
        mem_chk("R4", 16'h0106);

        // R2 + R3: page crossing the row end wraps to column 0
        cur_req = "R2/R3";
        do_load(16'h017E);
        for (int i = 0; i < 4; i++) do_byte(8'hA0 + i, 0);
        do_stop(1); idle(W + 3);
        mem_chk("R3", 16'h017E); mem_chk("R3", 16'h017F);
        mem_chk("R3", 16'h0100); mem_chk("R3", 16'h0101); mem_chk("R2", 16'h0180);

        // R3: 130 bytes, the last two replace columns 0 and 1
        cur_req = "R3/R4";
        do_load(16'h0200);
        for (int i = 0; i < 130; i++) do_byte((i * 7 + 3) & 255, 0);
        do_stop(1); idle(W + 3);
        mem_chk("R3", 16'h0200); mem_chk("R3", 16'h0201); mem_chk("R4", 16'h027F);

        // R6: misplaced stop discards
        cur_req = "R6";
        do_load(16'h0280); do_byte(8'h11, 0); do_byte(8'h22, 0);
        do_stop(0); idle(4); do_stop(1); idle(6);
        mem_chk("R6", 16'h0280); mem_chk("R6", 16'h0281);

        // R7: inhibited byte is not latched and blocks the commit
        cur_req = "R7";
        do_load(16'h0300); do_byte(8'h55, 0); do_byte(8'h66, 1); do_stop(1); idle(6);
        mem_chk("R7", 16'h0300); mem_chk("R7", 16'h0301);

        // R11: abort clears the latch
        cur_req = "R11";
        do_load(16'h0380);
        for (int i = 0; i < 3; i++) do_byte(8'h70 + i, 0);
        do_abort(); do_stop(1); idle(6);
        mem_chk("R11", 16'h0380);

        // R13: abort and stop in the same clock, abort wins
        cur_req = "R13";
        do_load(16'h0390); do_byte(8'h44, 0);
        step(1, 1, 1, 0, 0, 0, 0, 0); do_stop(1); idle(6);
        mem_chk("R13", 16'h0390);

        // R10: strobes during busy leave no trace
        cur_req = "R10";
        do_load(16'h0140); do_byte(8'h5A, 0); do_stop(1);
        do_load(16'h0010); do_byte(8'h99, 0); do_abort(); do_stop(1);
        idle(W); do_stop(1); idle(6);
        mem_chk("R10", 16'h0140); mem_chk("R10", 16'h0010); mem_chk("R10", 16'h0011);
        mem_chk("R12", 16'h03FF);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule